// File: doc/BRIEF.md
# Bidirectional Port Register Bank with Read-Side Polarity Inversion

This block keeps the control state for a small bidirectional general-purpose port, eight pins by default. It holds three writable registers (the drive value, a per-bit polarity mask and a per-bit direction) and presents a fourth, read-only view of the pins. Pin levels arrive already synchronised. The block turns the drive and direction registers into a value and an output enable for each tri-state pad.

A bus interface reaches the bank through a two-bit register select, a write strobe, write data and a read data output. The read data follows the select combinationally. A write is captured on the rising clock edge at which the strobe is high. The polarity mask changes only what is read back from the pin view. It never changes what is driven onto a pad. Electrical pad behaviour is outside this block.

Top module: `gpio_regbank`

## Requirements
- R1: While reset is held, and after it is released, the drive register reads 8'hFF, the polarity mask reads 8'h00, the direction register reads 8'hFF, and every pad_oe bit is 0, so every pin is an input.
- R2: With reg_sel = 0, rd_data equals pin_sync XOR polarity mask on every bit, whatever the direction of each pin.
- R3: A write with reg_sel = 0 changes none of the three stored registers.
- R4: With reg_sel = 1, rd_data returns the stored drive register, not the pin level.
- R5: On every bit, pad_out equals the drive register bit and pad_oe equals the inverse of the direction bit. A drive bit therefore never reaches a pad whose direction bit is 1.
- R6: A 1 in the polarity mask (reg_sel = 2) inverts that bit of the pin view. A 0 passes the bit through unchanged.
- R7: A 1 in the direction register (reg_sel = 3) makes the pin an input with its driver off. A 0 makes it an output.
- R8: A write is stored at the rising clock edge where wr_en is high and is not visible before that edge. With wr_en low, no register changes.
- R9: Reads with reg_sel = 2 and reg_sel = 3 return the stored polarity mask and the stored direction register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_sync | input | PINS | Synchronised pin levels |
| reg_sel | input | 2 | Register select: 0 pin view, 1 drive, 2 polarity, 3 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | PINS | Write data |
| rd_data | output | PINS | Read data for the selected register |
| pad_out | output | PINS | Value for each pad driver |
| pad_oe | output | PINS | Output enable for each pad driver, 1 = drive |

## Verification
On every cycle, the assertions check the pad mapping from the drive and direction state, the pin-view and drive-register read paths, the one-edge timing of a write, and that registers hold when no write is stored or when a write targets the read-only slot. The reset values and their return after a mid-run reset are also checked whenever reset is seen. Only the bench's scenarios can show that given data patterns read back with the right values, that a drive value stays readable while the pin shows something else, and that polarity and direction settings interact correctly across a sequence of writes.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;
  localparam int RB_SEL_W = 2;

  typedef enum logic [RB_SEL_W-1:0] {
    SEL_PINS   = 2'd0,
    SEL_DRIVE  = 2'd1,
    SEL_INVERT = 2'd2,
    SEL_DIR    = 2'd3
  } reg_sel_e;

  localparam int RB_NUM_STORED = 3;
endpackage

// File: rtl/gpio_rb_store.sv
module gpio_rb_store
  import gpio_rb_pkg::*;
#(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0,
  parameter logic [RB_SEL_W-1:0] MY_SEL = 2'd1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RB_SEL_W-1:0] reg_sel,
  input  logic [W-1:0]        wr_data,
  output logic                hit,
  output logic [W-1:0]        q
);
  assign hit = wr_en && (reg_sel == MY_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST_VAL;
    else if (hit) q <= wr_data;
  end
endmodule

// File: rtl/gpio_rb_rdmux.sv
module gpio_rb_rdmux
  import gpio_rb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [RB_SEL_W-1:0] reg_sel,
  input  logic [W-1:0]        pin_sync,
  input  logic [W-1:0]        drive_q,
  input  logic [W-1:0]        invert_q,
  input  logic [W-1:0]        dir_q,
  output logic [W-1:0]        rd_data
);
  function automatic logic [W-1:0] pin_view(input logic [W-1:0] lvl,
                                            input logic [W-1:0] mask);
    return lvl ^ mask;
  endfunction

  always_comb begin
    unique case (reg_sel)
      SEL_PINS:   rd_data = pin_view(pin_sync, invert_q);
      SEL_DRIVE:  rd_data = drive_q;
      SEL_INVERT: rd_data = invert_q;
      default:    rd_data = dir_q;
    endcase
  end
endmodule

// File: rtl/gpio_rb_pad.sv
module gpio_rb_pad #(
  parameter int W = 8
) (
  input  logic [W-1:0] drive_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  function automatic logic enable_of(input logic is_input);
    return ~is_input;
  endfunction

  for (genvar b = 0; b < W; b++) begin : g_pad
    assign pad_out[b] = drive_q[b];
    assign pad_oe[b]  = enable_of(dir_q[b]);
  end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PINS-1:0]     pin_sync,
  input  logic [RB_SEL_W-1:0] reg_sel,
  input  logic                wr_en,
  input  logic [PINS-1:0]     wr_data,
  output logic [PINS-1:0]     rd_data,
  output logic [PINS-1:0]     pad_out,
  output logic [PINS-1:0]     pad_oe
);
  localparam logic [PINS-1:0] ALL_ONE  = {PINS{1'b1}};
  localparam logic [PINS-1:0] ALL_ZERO = '0;

  // index 0: drive, 1: polarity mask, 2: direction
  logic [PINS-1:0]          store_q [RB_NUM_STORED];
  logic [RB_NUM_STORED-1:0] wr_hit;
  logic [PINS-1:0]          drive_q, invert_q, dir_q;

  for (genvar k = 0; k < RB_NUM_STORED; k++) begin : g_store
    localparam logic [PINS-1:0] RV = (k == 1) ? ALL_ZERO : ALL_ONE;
    localparam logic [RB_SEL_W-1:0] SV = RB_SEL_W'(k + 1);
    gpio_rb_store #(.W(PINS), .RST_VAL(RV), .MY_SEL(SV)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .reg_sel (reg_sel),
      .wr_data (wr_data),
      .hit     (wr_hit[k]),
      .q       (store_q[k])
    );
  end

  assign drive_q  = store_q[0];
  assign invert_q = store_q[1];
  assign dir_q    = store_q[2];

  gpio_rb_rdmux #(.W(PINS)) u_rdmux (
    .reg_sel  (reg_sel),
    .pin_sync (pin_sync),
    .drive_q  (drive_q),
    .invert_q (invert_q),
    .dir_q    (dir_q),
    .rd_data  (rd_data)
  );

  gpio_rb_pad #(.W(PINS)) u_pad (
    .drive_q (drive_q),
    .dir_q   (dir_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
  import gpio_rb_pkg::*;
#(
  parameter int PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PINS-1:0]     pin_sync,
  input logic [RB_SEL_W-1:0] reg_sel,
  input logic                wr_en,
  input logic [PINS-1:0]     wr_data,
  input logic [PINS-1:0]     rd_data,
  input logic [PINS-1:0]     pad_out,
  input logic [PINS-1:0]     pad_oe,
  input logic [PINS-1:0]     drive_q,
  input logic [PINS-1:0]     invert_q,
  input logic [PINS-1:0]     dir_q
);
  p_reset_vals_r1: assert property (@(posedge clk)
    !rst_n |=> (drive_q == {PINS{1'b1}} && invert_q == '0 &&
                dir_q == {PINS{1'b1}} && pad_oe == '0));

  p_pin_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_PINS) |-> (rd_data == (pin_sync ^ invert_q)));

  p_ro_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_PINS) |=>
      ($stable(drive_q) && $stable(invert_q) && $stable(dir_q)));

  p_drive_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_DRIVE) |-> (rd_data == drive_q));

  p_pad_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out == drive_q) && (pad_oe == ~dir_q));

  p_write_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_DRIVE) |=> (drive_q == $past(wr_data)));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(drive_q) && $stable(invert_q) && $stable(dir_q)));

  p_dir_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_DIR) |-> (rd_data == dir_q));
endmodule

bind gpio_regbank gpio_regbank_chk #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pin_sync (pin_sync),
  .reg_sel  (reg_sel),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .drive_q  (drive_q),
  .invert_q (invert_q),
  .dir_q    (dir_q)
);

// File: tb/sim_gpio_regbank.sv
`timescale 1ns/1ps
module sim_gpio_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_sync = 8'h00;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, pad_out, pad_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench-side register image
  logic [7:0] m_drive = 8'hFF, m_inv = 8'h00, m_dir = 8'hFF;

  always #2.5 clk = ~clk;

  gpio_regbank u0 (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {do_write, write_sel, write_data, read_sel, pins, expected_read}
  localparam int NV = 11;
  localparam logic [28:0] TBL [NV] = '{
    {1'b1, 2'd1, 8'hA5, 2'd1, 8'h00, 8'hA5},
    {1'b1, 2'd3, 8'hF0, 2'd3, 8'h3C, 8'hF0},
    {1'b0, 2'd0, 8'h00, 2'd0, 8'h3C, 8'h3C},
    {1'b1, 2'd2, 8'h0F, 2'd0, 8'h3C, 8'h33},
    {1'b1, 2'd0, 8'h00, 2'd2, 8'h3C, 8'h0F},
    {1'b1, 2'd0, 8'hFF, 2'd1, 8'h3C, 8'hA5},
    {1'b0, 2'd0, 8'h00, 2'd0, 8'hFF, 8'hF0},
    {1'b1, 2'd2, 8'hFF, 2'd0, 8'h00, 8'hFF},
    {1'b1, 2'd1, 8'h5A, 2'd1, 8'hA5, 8'h5A},
    {1'b1, 2'd3, 8'h00, 2'd3, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'h00, 2'd0, 8'hC3, 8'hC3}
  };

  task automatic check8(input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pads(input string tag);
    check8({tag, " pad_out"}, pad_out, m_drive);
    check8({tag, " pad_oe"}, pad_oe, ~m_dir);
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b0;
    reg_sel = s;
    #1 v = rd_data;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    // R1: values while reset held
    @(negedge clk);
    reg_sel = 2'd1; #1 check8("R1 drive in reset", rd_data, 8'hFF);
    check8("R1 pad_oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    read_reg(2'd1, v); check8("R1 drive after reset", v, 8'hFF);
    read_reg(2'd2, v); check8("R1 polarity after reset", v, 8'h00);
    read_reg(2'd3, v); check8("R1 direction after reset", v, 8'hFF);
    check8("R1 pad_oe after reset", pad_oe, 8'h00);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic       dw;
      logic [1:0] ws, rs;
      logic [7:0] wd, pv, ev;
      {dw, ws, wd, rs, pv, ev} = TBL[i];
      @(negedge clk);
      wr_en = dw; reg_sel = ws; wr_data = wd;
      if (dw) begin
        case (ws)
          2'd1: m_drive = wd;
          2'd2: m_inv = wd;
          2'd3: m_dir = wd;
          default: ;
        endcase
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; reg_sel = rs; pin_sync = pv;
      #1;
      check8($sformatf("R2/R3/R4/R6/R9 vector %0d read", i), rd_data, ev);
      check_pads($sformatf("R5/R7 vector %0d", i));
    end

    // R8: write not visible before the edge, visible after
    @(negedge clk);
    reg_sel = 2'd1; wr_data = 8'h3C; wr_en = 1'b1;
    #1 check8("R8 before edge", rd_data, 8'h5A);
    @(posedge clk);
    #1 check8("R8 after edge", rd_data, 8'h3C);
    m_drive = 8'h3C;
    // R8: strobe low holds
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h81; reg_sel = 2'd3;
    @(posedge clk);
    read_reg(2'd3, v); check8("R8 hold with strobe low", v, 8'h00);

    // R7/R5: mixed direction, drive only on output bits
    @(negedge clk);
    wr_en = 1'b1; reg_sel = 2'd3; wr_data = 8'hAA;
    @(posedge clk);
    m_dir = 8'hAA;
    @(negedge clk); wr_en = 1'b0;
    #1 check_pads("R7 mixed direction");

    // R2: pin view independent of direction, output pins show pin level
    pin_sync = 8'h96; reg_sel = 2'd0;
    #1 check8("R2 output pins visible", rd_data, 8'h96);
    // R4: drive readback differs from pin level
    reg_sel = 2'd1;
    #1 check8("R4 drive not pin", rd_data, 8'h3C);

    // R1: mid-run reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    #1 check8("R1 async reset pad_oe", pad_oe, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    m_drive = 8'hFF; m_inv = 8'h00; m_dir = 8'hFF;
    read_reg(2'd1, v); check8("R1 drive after mid reset", v, 8'hFF);
    read_reg(2'd3, v); check8("R1 direction after mid reset", v, 8'hFF);
    check_pads("R1 pads after mid reset");

    done = 1'b1;
    finish_run();
  end
endmodule